// File: doc/BRIEF.md
# Inline Packet Field Rewriter

This block sits in a streaming packet path, between the receive side of a link and whatever consumes the packets. Each beat carries a 64-bit data word and three markers: valid, start of packet and end of packet. Every beat leaves the block exactly one clock after it enters. The delay is the same whether or not the packet is altered, so the consumer downstream sees identical timing for rewritten and untouched traffic.

The first beat of a packet is its header. Bits [7:0] hold the packet kind and bits [63:32] hold the target address. On that beat a programmable rule is evaluated: the kind must equal a configured value and the address must fall inside an inclusive window. The result is kept until the next header. For a matching packet, one of three actions applies:

- **Payload rewrite.** Selected payload words are merged with a programmed value under a bit mask.
- **Kind rewrite.** The kind field of the header is replaced.
- **Address rewrite.** The address field of the header is replaced.

The default rule targets memory-write packets (kind `8'h40`), and the default action is the payload rewrite. A saturating-free wrap counter reports how many packets the block has acted on.

Top module: `pkt_field_rewriter`

## Requirements
- R1: `out_valid`, `out_sop` and `out_eop` equal `in_valid`, `in_sop` and `in_eop` from the previous clock.
- R2: While `cfg_enable` is low in the cycle a beat enters, that beat's data leaves unchanged one clock later. A header entering while `cfg_enable` is low never counts as a match.
- R3: A packet matches when all of the following hold on its header beat (valid and start both high, `cfg_enable` high):
  - bits [7:0] equal `cfg_kind`;
  - bits [63:32] are at least `cfg_addr_lo`;
  - bits [63:32] are at most `cfg_addr_hi`.
- R4: The match decision made on the header holds for every later beat of that packet. A change of `cfg_kind` or of the address window after the header does not alter it.
- R5: With `cfg_target` = 2'b00, a payload beat of a matching packet is rewritten as `(data & ~cfg_mask) | (cfg_value & cfg_mask)`. This applies when the beat is valid beat number k after the header (k = 1..NSEL) and `cfg_word_sel[k-1]` is set. Payload beats numbered above NSEL, and the header, are left unchanged.
- R6: With `cfg_target` = 2'b01, the header of a matching packet has bits [7:0] replaced by `cfg_value[7:0]`. All other bits and all payload beats are unchanged.
- R7: With `cfg_target` = 2'b10, the header of a matching packet has bits [63:32] replaced by `cfg_value[31:0]`. All other bits and all payload beats are unchanged.
- R8: With `cfg_target` = 2'b11, no data is altered and matching packets are not counted.
- R9: Beats of a packet that does not match leave bit-exact.
- R10: `mod_count` increases by one, wrapping modulo 2^CNT_W, on the clock that takes in the header of each matching packet whose `cfg_target` is not 2'b11. It never changes otherwise.
- R11: During reset, all output markers, `out_data` and `mod_count` are zero.
- R12: A beat with `in_valid` low does not advance the payload word number and is never rewritten. Its data still passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Rewriting on; when low the block is a plain register stage |
| cfg_kind | input | 8 | Packet kind to match in header bits [7:0] |
| cfg_addr_lo | input | 32 | Lowest matching address, inclusive |
| cfg_addr_hi | input | 32 | Highest matching address, inclusive |
| cfg_target | input | 2 | Action: 00 payload, 01 kind field, 10 address field, 11 none |
| cfg_word_sel | input | NSEL | Bit k-1 selects payload word k for rewriting |
| cfg_mask | input | DW | Bits of a selected payload word that are replaced |
| cfg_value | input | DW | Replacement value |
| in_data | input | DW | Incoming beat data |
| in_valid | input | 1 | Incoming beat valid |
| in_sop | input | 1 | Incoming beat is a packet header |
| in_eop | input | 1 | Incoming beat ends a packet |
| out_data | output | DW | Outgoing beat data, one clock later |
| out_valid | output | 1 | Outgoing beat valid |
| out_sop | output | 1 | Outgoing start marker |
| out_eop | output | 1 | Outgoing end marker |
| mod_count | output | CNT_W | Number of packets acted on |

## Verification
The assertions assume the stream is well formed: a start beat opens each packet, payload beats follow, and configuration is driven only from the clock edge's quiet side. They also assume the configuration is stable within the cycle a beat is sampled. They check relations between a beat and its predecessor, so they do not need packets to be closed by an end marker. The stimulus builds every packet from a header beat and numbered payload beats. It inserts idle cycles only between or inside packets, never with garbage markers. It changes configuration only on the falling clock edge, including the deliberate changes in the middle of a packet that exercise the held match decision.

// File: rtl/pkt_rw_pkg.sv
// Package: shared encodings and header field positions for the packet rewriter.
// Assumes a header beat at least 64 bits wide with kind in the low byte
// and address in the upper 32 bits.
package pkt_rw_pkg;

    typedef enum logic [1:0] {
        TGT_PAYLOAD = 2'b00,
        TGT_KIND    = 2'b01,
        TGT_ADDR    = 2'b10,
        TGT_NONE    = 2'b11
    } rw_target_e;

    localparam logic [7:0] KIND_MEM_WRITE = 8'h40;
    localparam int KIND_LSB = 0;
    localparam int KIND_W   = 8;
    localparam int ADDR_LSB = 32;
    localparam int ADDR_W   = 32;

endpackage

// File: rtl/pkt_rw_match.sv
// Module: header rule comparator.
// Decides whether a header's kind and address satisfy the programmed rule.
// Purely combinational; the caller qualifies the result with valid, start and enable.
module pkt_rw_match
    import pkt_rw_pkg::*;
(
    input  logic [KIND_W-1:0] hdr_kind,
    input  logic [ADDR_W-1:0] hdr_addr,
    input  logic [KIND_W-1:0] cfg_kind,
    input  logic [ADDR_W-1:0] cfg_addr_lo,
    input  logic [ADDR_W-1:0] cfg_addr_hi,
    output logic              rule_hit
);

    // Kind equality plus inclusive address window.
    always_comb begin
        rule_hit = (hdr_kind == cfg_kind)
                && (hdr_addr >= cfg_addr_lo)
                && (hdr_addr <= cfg_addr_hi);
    end

endmodule

// File: rtl/pkt_rw_track.sv
// Module: per-packet state tracker.
// Holds the match decision taken on the header until the next header, and
// numbers valid payload beats (header = 0), saturating at NSEL+1.
// Assumes every packet starts with a valid start beat.
module pkt_rw_track #(
    parameter int NSEL  = 8,
    parameter int IDX_W = $clog2(NSEL + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             start_hit,
    output logic             cur_hit,
    output logic [IDX_W-1:0] cur_idx
);

    localparam logic [IDX_W-1:0] IDX_SAT = IDX_W'(NSEL + 1);

    logic             hit_q;
    logic [IDX_W-1:0] idx_q;

    // Decision and word number that apply to the beat now at the input.
    always_comb begin
        cur_hit = (in_valid && in_sop) ? start_hit : hit_q;
        if (in_sop)
            cur_idx = '0;
        else if (idx_q == IDX_SAT)
            cur_idx = idx_q;
        else
            cur_idx = idx_q + 1'b1;
    end

    // Record the header's decision and the last valid beat's number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            idx_q <= '0;
        end else if (in_valid) begin
            if (in_sop)
                hit_q <= start_hit;
            idx_q <= cur_idx;
        end
    end

    AST_MATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_sop) |=> $stable(hit_q)); // R4

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_SAT); // R5

    AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(idx_q)); // R12

endmodule

// File: rtl/pkt_rw_apply.sv
// Module: data rewrite datapath.
// Produces the outgoing data word for the beat at the input, applying the
// selected action when the beat belongs to an active matching packet.
// Combinational; assumes cur_idx is 0 on a header beat.
module pkt_rw_apply
    import pkt_rw_pkg::*;
#(
    parameter int DW    = 64,
    parameter int NSEL  = 8,
    parameter int IDX_W = $clog2(NSEL + 2)
) (
    input  logic [DW-1:0]    data_in,
    input  logic             active,
    input  logic             is_hdr,
    input  logic [IDX_W-1:0] idx,
    input  rw_target_e       target,
    input  logic [NSEL-1:0]  word_sel,
    input  logic [DW-1:0]    mask,
    input  logic [DW-1:0]    value,
    output logic [DW-1:0]    data_out,
    output logic             touched
);

    logic [NSEL-1:0] sel_hot;

    // One decoder slice per selectable payload word.
    for (genvar g = 0; g < NSEL; g++) begin : g_word
        assign sel_hot[g] = word_sel[g] && (idx == IDX_W'(g + 1));
    end

    // Merge replacement value into the chosen word or header field.
    always_comb begin
        data_out = data_in;
        touched  = 1'b0;
        if (active) begin
            case (target)
                TGT_PAYLOAD: if (!is_hdr && (|sel_hot)) begin
                    data_out = (data_in & ~mask) | (value & mask);
                    touched  = 1'b1;
                end
                TGT_KIND: if (is_hdr) begin
                    data_out[KIND_LSB +: KIND_W] = value[KIND_W-1:0];
                    touched  = 1'b1;
                end
                TGT_ADDR: if (is_hdr) begin
                    data_out[ADDR_LSB +: ADDR_W] = value[ADDR_W-1:0];
                    touched  = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pkt_field_rewriter.sv
// Module: inline packet field rewriter, top level.
// Forwards every beat with a single register stage and rewrites matching
// packets in flight. Assumes DW >= 64 and a well-formed beat stream; no
// backpressure is handled.
module pkt_field_rewriter
    import pkt_rw_pkg::*;
#(
    parameter int DW    = 64,
    parameter int NSEL  = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic [7:0]       cfg_kind,
    input  logic [31:0]      cfg_addr_lo,
    input  logic [31:0]      cfg_addr_hi,
    input  logic [1:0]       cfg_target,
    input  logic [NSEL-1:0]  cfg_word_sel,
    input  logic [DW-1:0]    cfg_mask,
    input  logic [DW-1:0]    cfg_value,
    input  logic [DW-1:0]    in_data,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    output logic [DW-1:0]    out_data,
    output logic             out_valid,
    output logic             out_sop,
    output logic             out_eop,
    output logic [CNT_W-1:0] mod_count
);

    localparam int IDX_W = $clog2(NSEL + 2);

    rw_target_e       tgt;
    logic             rule_hit;
    logic             start_hit;
    logic             cur_hit;
    logic [IDX_W-1:0] cur_idx;
    logic [DW-1:0]    data_rw;
    logic             touched;
    logic             count_ev;
    logic             past_ok;

    assign tgt = rw_target_e'(cfg_target);

    pkt_rw_match u_match (
        .hdr_kind    (in_data[KIND_LSB +: KIND_W]),
        .hdr_addr    (in_data[ADDR_LSB +: ADDR_W]),
        .cfg_kind    (cfg_kind),
        .cfg_addr_lo (cfg_addr_lo),
        .cfg_addr_hi (cfg_addr_hi),
        .rule_hit    (rule_hit)
    );

    // A header counts as a match only while rewriting is enabled.
    always_comb start_hit = cfg_enable && rule_hit;

    pkt_rw_track #(.NSEL(NSEL), .IDX_W(IDX_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .start_hit (start_hit),
        .cur_hit   (cur_hit),
        .cur_idx   (cur_idx)
    );

    pkt_rw_apply #(.DW(DW), .NSEL(NSEL), .IDX_W(IDX_W)) u_apply (
        .data_in  (in_data),
        .active   (cfg_enable && in_valid && cur_hit),
        .is_hdr   (in_sop),
        .idx      (cur_idx),
        .target   (tgt),
        .word_sel (cfg_word_sel),
        .mask     (cfg_mask),
        .value    (cfg_value),
        .data_out (data_rw),
        .touched  (touched)
    );

    // Count event: matching header with an action that can alter data.
    always_comb count_ev = in_valid && in_sop && start_hit && (tgt != TGT_NONE);

    // Single output register stage for data and markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
        end else begin
            out_data  <= data_rw;
            out_valid <= in_valid;
            out_sop   <= in_sop;
            out_eop   <= in_eop;
        end
    end

    // Wrapping counter of packets acted on.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mod_count <= '0;
        else if (count_ev)
            mod_count <= mod_count + 1'b1;
    end

    // Marks that one clock has passed since reset, so $past is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n)
            past_ok <= 1'b0;
        else
            past_ok <= 1'b1;
    end

    AST_MARKER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (out_valid == $past(in_valid) && out_sop == $past(in_sop)
                     && out_eop == $past(in_eop))); // R1

    AST_BYPASS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(cfg_enable) |-> out_data == $past(in_data)); // R2

    AST_COUNT_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(cfg_enable) |-> $stable(mod_count)); // R2

    AST_UNTOUCHED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(touched) |-> out_data == $past(in_data)); // R9

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (mod_count == $past(mod_count)
                     || mod_count == CNT_W'($past(mod_count) + 1'b1))); // R10

endmodule

// File: tb/pkt_field_rewriter_tb.sv
module pkt_field_rewriter_tb_top;

    localparam int CLK_NS = 10;
    localparam int DW     = 64;
    localparam int NSEL   = 8;
    localparam int CNT_W  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            c_en = 1'b0;
    logic [7:0]      c_kind = 8'h40;
    logic [31:0]     c_lo = 32'h0000_1000;
    logic [31:0]     c_hi = 32'h0000_1FFF;
    logic [1:0]      c_tgt = 2'b00;
    logic [NSEL-1:0] c_sel = '0;
    logic [DW-1:0]   c_mask = '0;
    logic [DW-1:0]   c_val = '0;
    logic [DW-1:0]   i_data = '0;
    logic            i_valid = 1'b0;
    logic            i_sop = 1'b0;
    logic            i_eop = 1'b0;
    logic [DW-1:0]   o_data;
    logic            o_valid, o_sop, o_eop;
    logic [CNT_W-1:0] o_cnt;

    int    total = 0;
    int    bad = 0;
    bit    finished = 0;
    string scen = "";

    logic [DW-1:0] e_data = '0;
    logic          e_valid = 0, e_sop = 0, e_eop = 0;
    int            e_cnt = 0;
    bit            m_state = 0;
    int            m_idx = 0;
    string         e_tag = "R11";

    always #(CLK_NS/2) clk = ~clk;

    pkt_field_rewriter #(.DW(DW), .NSEL(NSEL), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(c_en), .cfg_kind(c_kind),
        .cfg_addr_lo(c_lo), .cfg_addr_hi(c_hi), .cfg_target(c_tgt),
        .cfg_word_sel(c_sel), .cfg_mask(c_mask), .cfg_value(c_val),
        .in_data(i_data), .in_valid(i_valid), .in_sop(i_sop), .in_eop(i_eop),
        .out_data(o_data), .out_valid(o_valid), .out_sop(o_sop), .out_eop(o_eop),
        .mod_count(o_cnt)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s%s act=%h exp=%h", tag, scen, act, exp);
        end
    endtask

    task automatic finish_up();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Behavioural reference: expected outputs after each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            e_data = '0; e_valid = 0; e_sop = 0; e_eop = 0;
            e_cnt = 0; m_state = 0; m_idx = 0; e_tag = "R11";
        end else begin
            logic [DW-1:0] d;
            string t;
            d = i_data;
            t = i_valid ? "R9" : "R12";
            if (i_valid && i_sop) begin
                m_state = c_en && (i_data[7:0] == c_kind)
                          && (i_data[63:32] >= c_lo) && (i_data[63:32] <= c_hi);
                m_idx = 0;
                if (m_state && c_tgt != 2'b11) e_cnt = (e_cnt + 1) % (1 << CNT_W);
            end else if (i_valid) begin
                if (m_idx < NSEL + 1) m_idx++;
            end
            if (!c_en) t = "R2";
            else if (i_valid && m_state) begin
                case (c_tgt)
                    2'b00: begin
                        t = "R5";
                        if (!i_sop && m_idx >= 1 && m_idx <= NSEL && c_sel[m_idx-1])
                            d = (d & ~c_mask) | (c_val & c_mask);
                    end
                    2'b01: begin t = "R6"; if (i_sop) d[7:0] = c_val[7:0]; end
                    2'b10: begin t = "R7"; if (i_sop) d[63:32] = c_val[31:0]; end
                    default: t = "R8";
                endcase
            end
            e_data = d; e_valid = i_valid; e_sop = i_sop; e_eop = i_eop; e_tag = t;
        end
    end

    // Compare every cycle on the falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1", {61'd0, o_valid, o_sop, o_eop}, {61'd0, e_valid, e_sop, e_eop});
            chk(e_tag, o_data, e_data);
            chk("R10", 64'(o_cnt), 64'(e_cnt));
        end
    end

    task automatic beat(input logic v, input logic s, input logic e, input logic [DW-1:0] d);
        @(negedge clk);
        i_valid = v; i_sop = s; i_eop = e; i_data = d;
    endtask

    function automatic logic [DW-1:0] hdr(input logic [7:0] kind, input logic [31:0] addr);
        return {addr, 24'h5AC396, kind};
    endfunction

    function automatic logic [DW-1:0] pay(input int k);
        return {32'hA5A5_0000 + 32'(k), 32'h0F0F_0000 ^ 32'(k * 7)};
    endfunction

    // Packet of n beats; an idle cycle is inserted before beat gap_at.
    task automatic send(input logic [7:0] kind, input logic [31:0] addr, input int n, input int gap_at);
        for (int i = 0; i < n; i++) begin
            if (i == gap_at) beat(0, 0, 0, 64'hDEAD_BEEF_0BAD_F00D);
            beat(1, i == 0, i == n - 1, (i == 0) ? hdr(kind, addr) : pay(i));
        end
        beat(0, 0, 0, 64'h1111_2222_3333_4444);
        @(negedge clk);
    endtask

    task automatic expect_cnt(input string tag, input int base, input int delta);
        chk(tag, 64'(o_cnt), 64'(base + delta));
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        chk("R11", {61'd0, o_valid, o_sop, o_eop}, 64'd0);
        chk("R11", o_data, 64'd0);
        chk("R11", 64'(o_cnt), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        scen = " (disabled)";
        c_sel = 8'hFF; c_mask = '1; c_val = 64'hCAFE_CAFE_CAFE_CAFE;
        base = int'(o_cnt); send(8'h40, 32'h1200, 4, 99); expect_cnt("R2", base, 0);

        scen = " (payload)";
        c_en = 1; c_sel = 8'b0000_0101; c_mask = 64'h00FF_00FF_FFFF_0000;
        base = int'(o_cnt); send(8'h40, 32'h1000, 5, 99); expect_cnt("R3", base, 1);
        base = int'(o_cnt); send(8'h40, 32'h1FFF, 4, 99); expect_cnt("R3", base, 1);
        base = int'(o_cnt); send(8'h40, 32'h0FFF, 4, 99); expect_cnt("R3", base, 0);
        base = int'(o_cnt); send(8'h40, 32'h2000, 4, 99); expect_cnt("R3", base, 0);
        base = int'(o_cnt); send(8'h00, 32'h1500, 4, 99); expect_cnt("R9", base, 0);

        scen = " (long packet)";
        c_sel = 8'hFF;
        base = int'(o_cnt); send(8'h40, 32'h1800, 12, 99); expect_cnt("R5", base, 1);

        scen = " (idle gap)";
        c_sel = 8'b0000_0110;
        send(8'h40, 32'h1800, 5, 2);

        scen = " (kind field)";
        c_tgt = 2'b01; c_val = 64'h0123_4567_89AB_CD7E;
        send(8'h40, 32'h1400, 3, 99);
        scen = " (addr field)";
        c_tgt = 2'b10;
        send(8'h40, 32'h1400, 3, 99);
        send(8'h40, 32'h1400, 1, 99);
        scen = " (no action)";
        c_tgt = 2'b11;
        base = int'(o_cnt); send(8'h40, 32'h1400, 3, 99); expect_cnt("R8", base, 0);

        scen = " (single beat payload)";
        c_tgt = 2'b00; c_sel = 8'hFF;
        send(8'h40, 32'h1400, 1, 99);

        scen = " (R4 rule change mid-packet)";
        beat(1, 1, 0, hdr(8'h40, 32'h1100));
        beat(1, 0, 0, pay(1));
        c_kind = 8'h20; c_lo = 32'hFFFF_0000;
        beat(1, 0, 0, pay(2));
        beat(1, 0, 1, pay(3));
        beat(0, 0, 0, '0);
        c_kind = 8'h40; c_lo = 32'h0000_1000;
        @(negedge clk);

        scen = " (enable drop mid-packet)";
        beat(1, 1, 0, hdr(8'h40, 32'h1100));
        beat(1, 0, 0, pay(1));
        c_en = 0;
        beat(1, 0, 0, pay(2));
        c_en = 1;
        beat(1, 0, 1, pay(3));
        beat(0, 0, 0, '0);
        repeat (2) @(negedge clk);

        if (!finished) finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=done");
            finish_up();
        end
    end

endmodule